// File: doc/BRIEF.md
# Register-Mapped Watchdog Timer

This block is a 32-bit watchdog on a simple word-addressed register bus. A down-counter loses one count on each cycle where an external 1 MHz tick enable is high and the timer is enabled. Software keeps the system alive by writing a 16-bit key to a write-only kick register, which reloads the counter from a programmable reload register. If the counter runs from 1 to 0 the block acts: it can pulse a system reset request, raise a sticky interrupt and pulse an external reset trigger, each chosen by a control bit. The counter then reloads.

A side input from the memory-controller reset logic changes what expiry does. While that input is high at expiry, no reset, interrupt or trigger is produced and the control word is cleared to zero, which stops the timer. Control writes are cleaned up on the way in: one nibble always reads back zero and the clock-select bit always reads back one. A pulse-shape register keeps a 20-bit width and two drive-style flags that change only when a key byte is written in its top eight bits. A mask register is plain storage.

Read data is combinational from the address. Only aligned 32-bit accesses take effect.

Top module: `wdog_timer`

## Requirements
- R1: After reset the count (offset 0x00) and the reload value (0x04) both read 0x014FB180, control (0x0C) reads 0x00000010, the pulse-shape register (0x18) reads 0x000000FF, the mask (0x1C) reads 0 and the kick register (0x08) reads 0.
- R2: A control write stores the written word with bits [11:8] forced to 0 and bit 4 forced to 1; bit 0 is enable, bit 1 selects the reset request, bit 2 the interrupt, bit 3 the external trigger.
- R3: While enabled, the count drops by exactly one on each clock where tick_i is high, and holds on every other clock.
- R4: A write to 0x08 whose low 16 bits equal 0x4755 reloads the count from the reload value and clears irq_o; any other value changes neither.
- R5: A control write that sets enable while it is clear loads the count from the reload value; a write that clears enable freezes the count.
- R6: When a tick takes the count from 1 to 0, the count reloads, wdt_reset_o is high for exactly one cycle if bit 1 is set, ext_trig_o is high for exactly one cycle if bit 3 is set, and irq_o is set and stays set if bit 2 is set.
- R7: If memrst_i is high when the count expires, none of the three outputs is asserted and control reads 0 afterwards.
- R8: Writes to 0x00 are ignored, accesses with a nonzero address bits [1:0] are ignored and read 0, and the unused offsets 0x10 and 0x14 read 0.
- R9: A write to 0x18 stores its low 20 bits, and bits [29:20] read 0; a top byte of 0xA5 sets bit 31, 0x5A clears bit 31, 0xA8 sets bit 30, 0x8A clears bit 30, and any other top byte leaves bits [31:30] as they were.
- R10: The mask register at 0x1C reads back the last word written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 1 MHz count enable, one clock wide |
| memrst_i | input | 1 | Memory-controller reset flag; suppresses expiry actions |
| req_valid_i | input | 1 | Bus access strobe |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | 5 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data for req_addr_i, combinational |
| wdt_reset_o | output | 1 | System reset request, one-cycle pulse |
| irq_o | output | 1 | Sticky expiry interrupt |
| ext_trig_o | output | 1 | External reset trigger, one-cycle pulse |

## Verification
The hardest situation to reach is expiry with the memory-controller flag raised, because the count starts near twenty million after reset and the flag only matters on the exact tick that takes the count from 1 to 0. The stimulus writes small reload values, kicks the timer to load them, and then sweeps every combination of the three action bits against both levels of the flag, issuing exactly as many ticks as the reload value. Pulse counts are gathered on the falling clock edge so that a pulse lasting more than one cycle shows up as a wrong count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DW = 32;

  // word indices (byte address >> 2)
  localparam int IX_COUNT  = 0;
  localparam int IX_RELOAD = 1;
  localparam int IX_KICK   = 2;
  localparam int IX_CTRL   = 3;
  localparam int IX_SHAPE  = 6;
  localparam int IX_MASK   = 7;

  localparam logic [15:0] KICK_KEY = 16'h4755;

  // control bit positions
  localparam int CB_EN   = 0;
  localparam int CB_RST  = 1;
  localparam int CB_IRQ  = 2;
  localparam int CB_EXT  = 3;
  localparam int CB_CLK  = 4;

  localparam logic [DW-1:0] CTRL_CLR_MASK = 32'h0000_0F00;
  localparam logic [DW-1:0] CTRL_SET_MASK = 32'h0000_0010;

  // pulse-shape key bytes
  localparam logic [7:0] KEY_POL_HI = 8'hA5;
  localparam logic [7:0] KEY_POL_LO = 8'h5A;
  localparam logic [7:0] KEY_DRV_PP = 8'hA8;
  localparam logic [7:0] KEY_DRV_OD = 8'h8A;

  function automatic logic [DW-1:0] clean_ctrl(input logic [DW-1:0] d);
    return (d & ~CTRL_CLR_MASK) | CTRL_SET_MASK;
  endfunction
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int W = 32,
  parameter logic [W-1:0] RESET_COUNT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         step;

  always_comb begin
    step     = tick_i & en_i & ~load_i;
    expire_o = step & (cnt_q == W'(1));
    cnt_d    = cnt_q;
    if (load_i || expire_o) begin
      cnt_d = reload_i;
    end else if (step && (cnt_q != '0)) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RESET_COUNT;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_actions.sv
module wdog_actions (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic memrst_i,
  input  logic sel_rst_i,
  input  logic sel_irq_i,
  input  logic sel_ext_i,
  input  logic kick_i,
  output logic wdt_reset_o,
  output logic irq_o,
  output logic ext_trig_o
);
  logic fire;
  logic rst_d, ext_d, irq_d;
  logic rst_q, ext_q, irq_q;

  always_comb begin
    fire  = expire_i & ~memrst_i;
    rst_d = fire & sel_rst_i;
    ext_d = fire & sel_ext_i;
    irq_d = irq_q;
    if (kick_i)                  irq_d = 1'b0;
    else if (fire && sel_irq_i)  irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      ext_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      rst_q <= rst_d;
      ext_q <= ext_d;
      irq_q <= irq_d;
    end
  end

  assign wdt_reset_o = rst_q;
  assign ext_trig_o  = ext_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SHAPE_W = 20,
  parameter logic [DW-1:0] RESET_COUNT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic [DW-1:0]     cnt_i,
  input  logic              expire_i,
  input  logic              memrst_i,
  output logic [DW-1:0]     rdata_o,
  output logic [DW-1:0]     ctrl_o,
  output logic [DW-1:0]     reload_o,
  output logic              load_o,
  output logic              kick_o
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [DW-1:0] SHAPE_MASK = DW'((64'd1 << SHAPE_W) - 1);

  logic [DW-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0] reload_q, reload_d;
  logic [DW-1:0] shape_q, shape_d;
  logic [DW-1:0] mask_q, mask_d;

  logic [IDX_W-1:0] idx;
  logic aligned, wr;
  logic wr_reload, wr_kick, wr_ctrl, wr_shape, wr_mask;
  logic [DW-1:0] ctrl_new;
  logic [7:0] key;

  always_comb begin
    idx       = req_addr_i[ADDR_W-1:2];
    aligned   = (req_addr_i[1:0] == 2'b00);
    wr        = req_valid_i & req_write_i & aligned;
    wr_reload = wr & (idx == IDX_W'(IX_RELOAD));
    wr_kick   = wr & (idx == IDX_W'(IX_KICK));
    wr_ctrl   = wr & (idx == IDX_W'(IX_CTRL));
    wr_shape  = wr & (idx == IDX_W'(IX_SHAPE));
    wr_mask   = wr & (idx == IDX_W'(IX_MASK));
    ctrl_new  = clean_ctrl(req_wdata_i);
    key       = req_wdata_i[DW-1:DW-8];

    kick_o = wr_kick & (req_wdata_i[15:0] == KICK_KEY);
    load_o = kick_o | (wr_ctrl & ctrl_new[CB_EN] & ~ctrl_q[CB_EN]);

    reload_d = wr_reload ? req_wdata_i : reload_q;
    mask_d   = wr_mask ? req_wdata_i : mask_q;

    ctrl_d = ctrl_q;
    if (expire_i && memrst_i) ctrl_d = '0;
    else if (wr_ctrl)         ctrl_d = ctrl_new;

    shape_d = shape_q;
    if (wr_shape) begin
      shape_d = (shape_q & ~SHAPE_MASK) | (req_wdata_i & SHAPE_MASK);
      shape_d[DW-3:SHAPE_W] = '0;
      if (key == KEY_POL_HI)      shape_d[DW-1] = 1'b1;
      else if (key == KEY_POL_LO) shape_d[DW-1] = 1'b0;
      else if (key == KEY_DRV_PP) shape_d[DW-2] = 1'b1;
      else if (key == KEY_DRV_OD) shape_d[DW-2] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= clean_ctrl('0);
      reload_q <= RESET_COUNT;
      shape_q  <= 32'h0000_00FF;
      mask_q   <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
      shape_q  <= shape_d;
      mask_q   <= mask_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      if (idx == IDX_W'(IX_COUNT))       rdata_o = cnt_i;
      else if (idx == IDX_W'(IX_RELOAD)) rdata_o = reload_q;
      else if (idx == IDX_W'(IX_CTRL))   rdata_o = ctrl_q;
      else if (idx == IDX_W'(IX_SHAPE))  rdata_o = shape_q;
      else if (idx == IDX_W'(IX_MASK))   rdata_o = mask_q;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SHAPE_W = 20,
  parameter logic [31:0] RESET_COUNT = 32'h014F_B180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              memrst_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic [31:0]       rsp_rdata_o,
  output logic              wdt_reset_o,
  output logic              irq_o,
  output logic              ext_trig_o
);
  logic [DW-1:0] cnt_w, ctrl_w, reload_w;
  logic          load_w, kick_w, expire_w;

  wdog_regs #(
    .ADDR_W(ADDR_W), .SHAPE_W(SHAPE_W), .RESET_COUNT(RESET_COUNT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .cnt_i(cnt_w), .expire_i(expire_w), .memrst_i(memrst_i),
    .rdata_o(rsp_rdata_o), .ctrl_o(ctrl_w), .reload_o(reload_w),
    .load_o(load_w), .kick_o(kick_w)
  );

  wdog_counter #(.W(DW), .RESET_COUNT(RESET_COUNT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(ctrl_w[CB_EN]),
    .load_i(load_w), .reload_i(reload_w), .cnt_o(cnt_w), .expire_o(expire_w)
  );

  wdog_actions u_act (
    .clk(clk), .rst_n(rst_n), .expire_i(expire_w), .memrst_i(memrst_i),
    .sel_rst_i(ctrl_w[CB_RST]), .sel_irq_i(ctrl_w[CB_IRQ]),
    .sel_ext_i(ctrl_w[CB_EXT]), .kick_i(kick_w),
    .wdt_reset_o(wdt_reset_o), .irq_o(irq_o), .ext_trig_o(ext_trig_o)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              memrst_i,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [31:0]       req_wdata_i,
  input logic              wdt_reset_o,
  input logic              irq_o,
  input logic              ext_trig_o,
  input logic [31:0]       cnt,
  input logic [31:0]       ctrl
);
  logic wr_any, kick_ok, ctrl_wr;
  assign wr_any  = req_valid_i & req_write_i & (req_addr_i[1:0] == 2'b00);
  assign kick_ok = wr_any & (req_addr_i == ADDR_W'(8)) & (req_wdata_i[15:0] == 16'h4755);
  assign ctrl_wr = wr_any & (req_addr_i == ADDR_W'(12));

  assert_ctrl_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_wr && !memrst_i) |-> (ctrl[4] && ctrl[11:8] == 4'h0));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick_i && ctrl[0] && cnt > 32'd1 && !kick_ok && !ctrl_wr)
      |-> cnt == $past(cnt) - 32'd1);

  assert_irq_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(kick_ok));

  assert_reset_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_o |=> !wdt_reset_o);

  assert_ext_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_trig_o |=> !ext_trig_o);

  assert_memrst_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_reset_o || ext_trig_o) |-> $past(!memrst_i));
endmodule

bind wdog_timer wdog_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .memrst_i(memrst_i),
  .req_valid_i(req_valid_i), .req_write_i(req_write_i),
  .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
  .wdt_reset_o(wdt_reset_o), .irq_o(irq_o), .ext_trig_o(ext_trig_o),
  .cnt(cnt_w), .ctrl(ctrl_w)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  logic        clk, rst_n, tick, memrst;
  logic        valid, write;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata;
  logic        wdt_rst, irq, ext;
  int total = 0, bad = 0;
  int n_rst = 0, n_ext = 0;

  wdog_timer u_wdog_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .memrst_i(memrst),
    .req_valid_i(valid), .req_write_i(write), .req_addr_i(addr),
    .req_wdata_i(wdata), .rsp_rdata_o(rdata),
    .wdt_reset_o(wdt_rst), .irq_o(irq), .ext_trig_o(ext)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (wdt_rst) n_rst++;
    if (ext)     n_ext++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog timeout");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; tick = 1'b0; memrst = 1'b0;
    valid = 1'b0; write = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(5'h00, v); chk("R1 count", v, 32'h014F_B180);
    bus_rd(5'h04, v); chk("R1 reload", v, 32'h014F_B180);
    bus_rd(5'h08, v); chk("R1 kick", v, 32'h0);
    bus_rd(5'h0C, v); chk("R1 ctrl", v, 32'h10);
    bus_rd(5'h18, v); chk("R1 shape", v, 32'hFF);
    bus_rd(5'h1C, v); chk("R1 mask", v, 32'h0);
    chk("R1 outputs", {29'b0, wdt_rst, irq, ext}, 32'h0);

    // R8 unused and unaligned
    bus_rd(5'h10, v); chk("R8 unused 0x10", v, 32'h0);
    bus_rd(5'h14, v); chk("R8 unused 0x14", v, 32'h0);
    bus_rd(5'h05, v); chk("R8 unaligned read", v, 32'h0);
    bus_wr(5'h06, 32'h1234_5678);
    bus_rd(5'h04, v); chk("R8 unaligned write", v, 32'h014F_B180);
    bus_wr(5'h00, 32'h0000_0033);
    bus_rd(5'h00, v); chk("R8 count write", v, 32'h014F_B180);

    // R2 sanitise sweep over every bit
    for (int b = 0; b < 32; b++) begin
      logic [31:0] d;
      d = 32'h1 << b;
      bus_wr(5'h0C, d);
      bus_rd(5'h0C, v);
      chk("R2 ctrl clean", v, (d & ~32'h0F00) | 32'h10);
      bus_wr(5'h0C, 32'h0);
    end
    bus_rd(5'h0C, v); chk("R2 ctrl zero write", v, 32'h10);

    // R5 / R3 counting
    bus_wr(5'h04, 32'd20);
    bus_rd(5'h00, v); chk("R5 reload write only", v, 32'h014F_B180);
    ticks(2);
    bus_rd(5'h00, v); chk("R3 disabled hold", v, 32'h014F_B180);
    bus_wr(5'h0C, 32'h1);
    bus_rd(5'h00, v); chk("R5 enable load", v, 32'd20);
    for (int k = 1; k <= 10; k++) begin
      ticks(1);
      bus_rd(5'h00, v); chk("R3 step", v, 32'd20 - k);
    end
    repeat (4) @(negedge clk);
    bus_rd(5'h00, v); chk("R3 no tick hold", v, 32'd10);
    bus_wr(5'h0C, 32'h11);
    bus_rd(5'h00, v); chk("R5 re-enable no load", v, 32'd10);
    bus_wr(5'h0C, 32'h10);
    ticks(3);
    bus_rd(5'h00, v); chk("R5 disable freeze", v, 32'd10);

    // R4 kick key
    bus_wr(5'h08, 32'h0000_4756);
    bus_rd(5'h00, v); chk("R4 wrong key", v, 32'd10);
    bus_wr(5'h08, 32'h1234_4755);
    bus_rd(5'h00, v); chk("R4 key reload", v, 32'd20);
    bus_rd(5'h08, v); chk("R4 kick reads 0", v, 32'h0);

    // R6 / R7 expiry sweep
    for (int m = 0; m < 2; m++) begin
      for (int f = 0; f < 8; f++) begin
        int r, r0, e0;
        logic [31:0] c;
        r = 1 + (f % 3);
        c = 32'h11 | (32'(f) << 1);
        memrst = 1'b0;
        bus_wr(5'h0C, 32'h10);
        bus_wr(5'h04, 32'(r));
        bus_wr(5'h08, 32'h4755);
        memrst = (m == 1);
        bus_wr(5'h0C, c);
        r0 = n_rst; e0 = n_ext;
        ticks(r);
        repeat (3) @(negedge clk);
        chk((m == 1) ? "R7 reset pulses" : "R6 reset pulses", 32'(n_rst - r0),
            32'((f & 1) != 0 && m == 0));
        chk((m == 1) ? "R7 ext pulses" : "R6 ext pulses", 32'(n_ext - e0),
            32'((f & 4) != 0 && m == 0));
        chk((m == 1) ? "R7 irq" : "R6 irq sticky", {31'b0, irq},
            32'((f & 2) != 0 && m == 0));
        bus_rd(5'h00, v); chk("R6 reload after expiry", v, 32'(r));
        bus_rd(5'h0C, v);
        chk((m == 1) ? "R7 ctrl cleared" : "R6 ctrl kept", v, (m == 1) ? 32'h0 : c);
        if (irq) begin
          bus_wr(5'h08, 32'h0000_4754);
          chk("R4 wrong key keeps irq", {31'b0, irq}, 32'h1);
          bus_wr(5'h08, 32'hFFFF_4755);
          chk("R4 key clears irq", {31'b0, irq}, 32'h0);
        end
      end
    end
    memrst = 1'b0;
    bus_wr(5'h0C, 32'h10);

    // R9 pulse-shape register
    bus_wr(5'h18, 32'hA500_0123); bus_rd(5'h18, v); chk("R9 pol high", v, 32'h8000_0123);
    bus_wr(5'h18, 32'hA800_0FFF); bus_rd(5'h18, v); chk("R9 push pull", v, 32'hC000_0FFF);
    bus_wr(5'h18, 32'h5A0A_BCDE); bus_rd(5'h18, v); chk("R9 pol low", v, 32'h400A_BCDE);
    bus_wr(5'h18, 32'h8A00_0001); bus_rd(5'h18, v); chk("R9 open drain", v, 32'h0000_0001);
    bus_wr(5'h18, 32'hA500_0000);
    bus_wr(5'h18, 32'h1234_5678); bus_rd(5'h18, v); chk("R9 other key", v, 32'h8004_5678);

    // R10 mask storage
    bus_wr(5'h1C, 32'hDEAD_BEEF); bus_rd(5'h1C, v); chk("R10 mask", v, 32'hDEAD_BEEF);
    bus_wr(5'h1C, 32'h0F0F_0001); bus_rd(5'h1C, v); chk("R10 mask rewrite", v, 32'h0F0F_0001);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule